// File: doc/BRIEF.md
# Peripheral Clock and Register-Access Disable Controller

This block lets software switch individual peripherals off. A processor-side configuration port writes and reads a disable vector that holds one bit per peripheral. From that vector the block derives, for each peripheral, a clock enable for the clock-gating cells outside this block and a register-access enable. Both enables change only on the instruction-cycle strobe. A write therefore takes effect at the end of the instruction cycle that follows it.

The block also sits in the access path to the peripherals' own control and status registers. A write that targets a disabled peripheral is not passed on. A read from a disabled peripheral returns all zeros. Every access finishes in the cycle it is issued, whether or not it is blocked. Two build-time masks set the variant. One says which peripherals exist. The other says which bits stay readable and writable even when their peripheral is absent.

Top module: `periph_gate_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no configuration write, the disable vector reads 0 and clk_en_o and reg_en_o both equal the presence mask.
- R2: A configuration write stores cfg_wdata_i into every bit that is either present or marked read/write capable. The new value appears on cfg_rdata_o in the following cycle.
- R3: A disable bit whose peripheral is absent and not marked read/write capable always reads 0, and writing 1 to it changes nothing on any output.
- R4: Each enable bit equals (disable bit clear) AND (peripheral present). A read/write-capable bit of an absent peripheral reads back 1 when set, but its enable stays 0. clk_en_o and reg_en_o are always equal.
- R5: On a clock edge where icyc_stb_i is 1, the enables load the value derived from the disable vector held before that edge. A configuration write made on the same edge as the strobe shows on the enables only at the next strobe.
- R6: On an edge where icyc_stb_i is 0, the enable outputs keep their value, however many configuration writes occur.
- R7: An access with acc_req_i=1 and acc_wr_i=1 raises per_wr_o bit acc_idx_i in the same cycle only if that peripheral is enabled. At most one per_wr_o bit is ever high, and per_wdata_o carries acc_wdata_i.
- R8: A read (acc_req_i=1, acc_wr_i=0) returns the 16-bit slice acc_idx_i of per_rdata_i (bits 16*i+15 down to 16*i) in the same cycle when that peripheral is enabled. It returns all zeros when the peripheral is disabled or when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| icyc_stb_i | input | 1 | One-clock strobe marking the end of each instruction cycle |
| cfg_wr_i | input | 1 | Write strobe for the disable vector |
| cfg_wdata_i | input | 16 | New disable vector |
| cfg_rdata_o | output | 16 | Current disable vector |
| clk_en_o | output | 16 | Per-peripheral clock enable |
| reg_en_o | output | 16 | Per-peripheral register-access enable |
| acc_req_i | input | 1 | Peripheral register access request |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_idx_i | input | 4 | Index of the target peripheral |
| acc_wdata_i | input | 16 | Write data for the peripheral |
| acc_rdata_o | output | 16 | Qualified read data |
| per_wr_o | output | 16 | Qualified per-peripheral write strobes |
| per_wdata_o | output | 16 | Write data broadcast to the peripherals |
| per_rdata_i | input | 256 | Concatenated peripheral read data, 16 bits each |

## Verification
A corrupted disable vector shows on cfg_rdata_o one cycle after the write that caused it. It reaches the enable outputs at the next instruction-cycle strobe. A wrong enable stage shows at clk_en_o and reg_en_o from the edge where it goes wrong. It also shows at once as a missing or extra per_wr_o strobe, or as a wrong acc_rdata_o, on any access to the affected peripheral. For this reason the bench checks every output against its model on every cycle, with strobes at both regular and irregular spacing and with writes that land on strobe edges.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int unsigned PGC_DATA_W = 16;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } pgc_acc_e;
endpackage

// File: rtl/pgc_dis_reg.sv
module pgc_dis_reg #(
  parameter int unsigned N = 16,
  parameter logic [N-1:0] PRESENT = '1,
  parameter logic [N-1:0] RW_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] dis_o
);
  localparam logic [N-1:0] WMASK = PRESENT | RW_MASK;

  logic [N-1:0] dis_d;
  logic [N-1:0] dis_q;

  always_comb begin
    if (wr_i) dis_d = wdata_i & WMASK;
    else      dis_d = dis_q;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (WMASK[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dis_q[i] <= 1'b0;
        else        dis_q[i] <= dis_d[i];
      end
    end else begin : g_tie
      assign dis_q[i] = 1'b0;
    end
  end

  assign dis_o = dis_q;

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> dis_o == ($past(wdata_i) & WMASK));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(dis_o));
endmodule

// File: rtl/pgc_en_stage.sv
module pgc_en_stage #(
  parameter int unsigned N = 16,
  parameter logic [N-1:0] PRESENT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_d;
  logic [N-1:0] en_q;

  always_comb begin
    if (stb_i) en_d = ~dis_i & PRESENT;
    else       en_d = en_q;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (PRESENT[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q[i] <= 1'b1;
        else        en_q[i] <= en_d[i];
      end
    end else begin : g_tie
      assign en_q[i] = 1'b0;
    end
  end

  assign en_o = en_q;

  // R5
  stb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i |=> en_o == (~$past(dis_i) & PRESENT));
  // R6
  no_stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(en_o));
endmodule

// File: rtl/pgc_access_gate.sv
module pgc_access_gate
  import pgc_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    en_i,
  input  logic            req_i,
  input  logic            wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [N*DW-1:0] per_rdata_i,
  output logic [N-1:0]    per_wr_o,
  output logic [DW-1:0]   per_wdata_o,
  output logic [DW-1:0]   rdata_o
);
  pgc_acc_e     kind;
  logic [N-1:0] hit;
  logic [N-1:0] rd_sel;

  always_comb begin
    if (!req_i)    kind = ACC_IDLE;
    else if (wr_i) kind = ACC_WRITE;
    else           kind = ACC_READ;
  end

  for (genvar i = 0; i < N; i++) begin : g_per
    assign hit[i]      = (idx_i == IDX_W'(i));
    assign per_wr_o[i] = (kind == ACC_WRITE) && hit[i] && en_i[i];
    assign rd_sel[i]   = (kind == ACC_READ)  && hit[i] && en_i[i];
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel[i]) rdata_o = rdata_o | per_rdata_i[i*DW +: DW];
    end
  end

  assign per_wdata_o = wdata_i;

  // R7
  one_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_wr_o));
  // R7
  wr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_wr_o & ~en_i) == '0);
  // R8
  blocked_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !wr_i && (en_i & hit) == '0) |-> rdata_o == '0);
endmodule

// File: rtl/periph_gate_ctrl.sv
module periph_gate_ctrl #(
  parameter int unsigned NUM_PERIPH = 16,
  parameter int unsigned DATA_W     = pgc_pkg::PGC_DATA_W,
  parameter logic [NUM_PERIPH-1:0] PRESENT_MASK = '1,
  parameter logic [NUM_PERIPH-1:0] RW_MASK      = '0,
  localparam int unsigned IDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       icyc_stb_i,
  input  logic                       cfg_wr_i,
  input  logic [NUM_PERIPH-1:0]      cfg_wdata_i,
  output logic [NUM_PERIPH-1:0]      cfg_rdata_o,
  output logic [NUM_PERIPH-1:0]      clk_en_o,
  output logic [NUM_PERIPH-1:0]      reg_en_o,
  input  logic                       acc_req_i,
  input  logic                       acc_wr_i,
  input  logic [IDX_W-1:0]           acc_idx_i,
  input  logic [DATA_W-1:0]          acc_wdata_i,
  output logic [DATA_W-1:0]          acc_rdata_o,
  output logic [NUM_PERIPH-1:0]      per_wr_o,
  output logic [DATA_W-1:0]          per_wdata_o,
  input  logic [NUM_PERIPH*DATA_W-1:0] per_rdata_i
);
  logic [1:0]            rst_sync_q;
  logic                  rst_n_int;
  logic [NUM_PERIPH-1:0] dis_vec;
  logic [NUM_PERIPH-1:0] en_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  pgc_dis_reg #(
    .N(NUM_PERIPH), .PRESENT(PRESENT_MASK), .RW_MASK(RW_MASK)
  ) u_dis_reg (
    .clk(clk), .rst_n(rst_n_int), .wr_i(cfg_wr_i),
    .wdata_i(cfg_wdata_i), .dis_o(dis_vec)
  );

  pgc_en_stage #(
    .N(NUM_PERIPH), .PRESENT(PRESENT_MASK)
  ) u_en_stage (
    .clk(clk), .rst_n(rst_n_int), .stb_i(icyc_stb_i),
    .dis_i(dis_vec), .en_o(en_vec)
  );

  pgc_access_gate #(
    .N(NUM_PERIPH), .DW(DATA_W), .IDX_W(IDX_W)
  ) u_gate (
    .clk(clk), .rst_n(rst_n_int), .en_i(en_vec),
    .req_i(acc_req_i), .wr_i(acc_wr_i), .idx_i(acc_idx_i),
    .wdata_i(acc_wdata_i), .per_rdata_i(per_rdata_i),
    .per_wr_o(per_wr_o), .per_wdata_o(per_wdata_o), .rdata_o(acc_rdata_o)
  );

  assign cfg_rdata_o = dis_vec;
  assign clk_en_o    = en_vec;
  assign reg_en_o    = en_vec;

  // R4
  absent_off_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (clk_en_o & ~PRESENT_MASK) == '0 && clk_en_o == reg_en_o);
  // R3
  fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cfg_rdata_o & ~(PRESENT_MASK | RW_MASK)) == '0);
endmodule

// File: tb/periph_gate_ctrl_bench.sv
`timescale 1ns/1ps
module periph_gate_ctrl_bench;
  localparam int N = 16;
  localparam logic [15:0] PRES = 16'h7F3B;
  localparam logic [15:0] RWM  = 16'h0004;
  localparam logic [15:0] WMSK = PRES | RWM;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, cfg_wr = 1'b0, req = 1'b0, wr = 1'b0;
  logic [15:0] cfg_wdata = '0, acc_wdata = '0, salt = '0;
  logic [3:0] idx = '0;
  logic [15:0] cfg_rdata, clk_en, reg_en, acc_rdata, per_wr, per_wdata;
  logic [N*16-1:0] per_rdata;

  int n_chk = 0, n_fail = 0;
  bit run = 1'b0, done = 1'b0;
  logic [15:0] m_dis, m_en;

  always #2 clk = ~clk;

  function automatic logic [15:0] pdat(int i);
    return 16'h5A00 ^ (16'(i) * 16'h0111) ^ salt;
  endfunction

  always_comb for (int i = 0; i < N; i++) per_rdata[i*16 +: 16] = pdat(i);

  periph_gate_ctrl #(.NUM_PERIPH(16), .DATA_W(16), .PRESENT_MASK(PRES), .RW_MASK(RWM))
  u_periph_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .icyc_stb_i(stb), .cfg_wr_i(cfg_wr),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .clk_en_o(clk_en),
    .reg_en_o(reg_en), .acc_req_i(req), .acc_wr_i(wr), .acc_idx_i(idx),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata), .per_wr_o(per_wr),
    .per_wdata_o(per_wdata), .per_rdata_i(per_rdata)
  );

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dis = 16'h0000;
      m_en  = PRES;
    end else begin
      if (stb) m_en = ~m_dis & PRES;
      if (cfg_wr) m_dis = cfg_wdata & WMSK;
    end
  end

  always @(negedge clk) begin
    if (run) begin
      logic [15:0] e_wr, e_rd;
      e_wr = (req && wr && m_en[idx]) ? (16'd1 << idx) : 16'd0;
      e_rd = (req && !wr && m_en[idx]) ? pdat(int'(idx)) : 16'd0;
      check(cfg_rdata === m_dis, "R2/R3 cfg_rdata", cfg_rdata, m_dis);
      check(clk_en === m_en, "R5 clk_en", clk_en, m_en);
      check(reg_en === m_en, "R4 reg_en", reg_en, m_en);
      check(per_wr === e_wr, "R7 per_wr", per_wr, e_wr);
      check(acc_rdata === e_rd, "R8 acc_rdata", acc_rdata, e_rd);
      if (req && wr) check(per_wdata === acc_wdata, "R7 per_wdata", per_wdata, acc_wdata);
    end
  end

  task automatic drive(bit s, bit cw, logic [15:0] cd, bit rq, bit w, logic [3:0] ix, logic [15:0] wd);
    @(posedge clk); #1;
    stb = s; cfg_wr = cw; cfg_wdata = cd; req = rq; wr = w; idx = ix; acc_wdata = wd;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got %h expected %h", 16'h0, 16'h1);
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    check(cfg_rdata === 16'h0, "R1 reset cfg_rdata", cfg_rdata, 16'h0);
    check(clk_en === PRES, "R1 reset clk_en", clk_en, PRES);
    check(reg_en === PRES, "R1 reset reg_en", reg_en, PRES);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (4) drive(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0);
    #1 check(clk_en === PRES, "R1 after release", clk_en, PRES);

    // R3 / R4: write all ones, no strobe
    drive(1'b0, 1'b1, 16'hFFFF, 1'b0, 1'b0, 4'd0, 16'h0);
    drive(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0);
    check(cfg_rdata === WMSK, "R3 writable bits only", cfg_rdata, WMSK);
    check(cfg_rdata[2] === 1'b1, "R4 rw bit reads 1", {15'h0, cfg_rdata[2]}, 16'h1);
    // R6: no strobe, enables hold
    repeat (3) drive(1'b0, 1'b1, 16'hFFFF, 1'b1, 1'b1, 4'd3, 16'h1234);
    check(clk_en === PRES, "R6 hold without strobe", clk_en, PRES);
    drive(1'b1, 1'b0, 16'h0, 1'b1, 1'b1, 4'd3, 16'h1234);
    drive(1'b0, 1'b0, 16'h0, 1'b1, 1'b1, 4'd3, 16'h1234);
    check(clk_en === 16'h0, "R5 disabled after strobe", clk_en, 16'h0);
    #1 check(per_wr === 16'h0, "R7 write dropped", per_wr, 16'h0);
    drive(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 4'd3, 16'h0);
    #1 check(acc_rdata === 16'h0, "R8 read masked", acc_rdata, 16'h0);

    // R5: write on strobe edge shows at next strobe
    drive(1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 4'd0, 16'h0);
    drive(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0);
    check(clk_en === 16'h0, "R5 same-edge write delayed", clk_en, 16'h0);
    drive(1'b1, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0);
    drive(1'b0, 1'b0, 16'h0, 1'b1, 1'b0, 4'd4, 16'h0);
    check(clk_en === PRES, "R5 re-enabled", clk_en, PRES);
    #1 check(acc_rdata === pdat(4), "R8 enabled read", acc_rdata, pdat(4));

    // R4: rw-capable absent bit set, enable stays 0
    drive(1'b1, 1'b1, 16'h0004, 1'b0, 1'b0, 4'd0, 16'h0);
    drive(1'b1, 1'b0, 16'h0, 1'b1, 1'b1, 4'd2, 16'h0);
    drive(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0);
    check(cfg_rdata === 16'h0004 && clk_en === PRES, "R4 rw bit no enable", clk_en, PRES);

    // random traffic, strobe every 3 clocks or irregular
    for (int c = 0; c < 6000; c++) begin
      bit s;
      s = (c < 3000) ? (c % 3 == 0) : ($urandom_range(0, 3) == 0);
      if (c % 97 == 0) salt = 16'($urandom);
      drive(s, ($urandom_range(0, 4) == 0), 16'($urandom), $urandom_range(0, 1) == 1,
            $urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)), 16'($urandom));
    end
    drive(1'b0, 1'b0, 16'h0, 1'b0, 1'b0, 4'd0, 16'h0);
    @(negedge clk);
    run = 1'b0;
    finish_up();
  end
endmodule